// File: doc/BRIEF.md
# SIMD Power-Domain Sequencer

This controller switches the separately powered domain of a SIMD coprocessor on and off. It drives four control lines, all in one clock domain: the core reset, the SIMD unit's reset, an enable for the clamps on the domain's outputs, and the enable of the power switch. It enforces a fixed order of reset, clamp and power steps, with minimum cycle counts between them. Software and the system start a flow with a one-cycle request pulse on one of four request inputs. It reads progress from a two-bit status and a "may enable" flag. No bus is involved.

When the controller comes out of its own reset it runs a cold power-on. The SIMD domain stays unpowered and clamped, and the core is released while the SIMD reset stays asserted. After that there are four flows. Two power the domain down: one holds the core in reset during the flow, the other lets the core keep running. Two power it up, with the same choice. Each change of the power-switch enable waits for a power-good acknowledge from the switch before the flow continues. A request that is malformed, that does not fit the current state, or that arrives while a flow is running is dropped and flagged for one cycle.

Top module: `simd_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `simd_rst_n`, `clamp_en` and `pwr_en` are all 0 and `status` is 3.
- R2: Cold power-on. `clamp_en` rises exactly HOLD_CYC (8) cycles after `rst_n` is released, with both resets low throughout. `pwr_en` never rises. Once `pwr_ack` is low, `core_rst_n` is released two cycles after the clamp (lat 0), while `simd_rst_n` stays low and `status` becomes 0.
- R3: Power-down with the core held (request bit 0, accepted only when ON). Both resets go low on the accepting edge. `clamp_en` rises HOLD_CYC cycles later and `pwr_en` falls one cycle after that. When `pwr_ack` is low, `core_rst_n` returns high on the next edge and `simd_rst_n` stays low.
- R4: Power-down with the core running (request bit 1). It is accepted only when ON and `sw_off` is 1. It follows the R3 timing, except that `core_rst_n` never goes low.
- R5: Power-up with the core held (request bit 2, accepted only when OFF). `core_rst_n` goes low on the accepting edge and `pwr_en` rises one cycle later. `clamp_en` falls on the first edge that sees `pwr_ack` high. Both resets rise one cycle after that.
- R6: Power-up with the core running (request bit 3, accepted only when OFF). `pwr_en` rises on the accepting edge. `simd_rst_n` rises on the first edge that sees `pwr_ack` high. `clamp_en` falls exactly SETTLE_CYC (20) cycles later, in the same cycle that `may_enable` rises.
- R7: `may_enable` falls on the edge that accepts any power-down request.
- R8: A request is dropped, and `req_err` is 1 for the following cycle, in three cases: more than one request bit is set, the request does not fit the state, or a flow is running. A dropped request leaves the four control outputs and the status unchanged, and a running flow keeps its timing.
- R9: `status` encodes 0 for off, 1 for powering up, 2 for on and 3 for powering down.
- R10: `simd_rst_n` rises only while `pwr_en` is high. `clamp_en` falls only while `pwr_en` and `pwr_ack` are both high. `pwr_en` changes only while `clamp_en` is high and `simd_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller; its release starts the cold power-on |
| req | input | 4 | One-cycle request pulse: bit 0 down/core held, bit 1 down/core running, bit 2 up/core held, bit 3 up/core running |
| sw_off | input | 1 | Software indication that the SIMD unit is disabled |
| pwr_ack | input | 1 | Power-good acknowledge from the power switch; follows `pwr_en` |
| core_rst_n | output | 1 | Active-low core reset |
| simd_rst_n | output | 1 | Active-low SIMD unit reset |
| clamp_en | output | 1 | Output clamp enable for the SIMD domain |
| pwr_en | output | 1 | Power-switch enable for the SIMD domain |
| status | output | 2 | Domain status, encoded as in R9 |
| may_enable | output | 1 | Software may enable the SIMD unit |
| req_err | output | 1 | The request of the previous cycle was dropped |

## Verification
The assertions assume that `pwr_ack` follows `pwr_en` monotonically after some delay, and that it never rises while the enable is low or falls while it is high. The bench keeps to this by deriving the acknowledge from a shift register fed by `pwr_en`, with the delay swept from zero to three cycles. The assertions also assume that `rst_n` is held low for at least one edge. Request pulses last exactly one cycle, and they include the malformed, misplaced and mid-flow requests that the error rule covers.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int NREQ = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_CUT, ST_WAIT_OFF, ST_PREP, ST_WAIT_ON, ST_REL, ST_SETTLE
  } step_t;

  // Flow index equals the request bit that starts it.
  typedef enum logic [1:0] {
    FL_DN_HOLD = 2'd0, FL_DN_RUN = 2'd1, FL_UP_HOLD = 2'd2, FL_UP_RUN = 2'd3
  } flow_t;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0, PS_RISING = 2'd1, PS_ON = 2'd2, PS_FALLING = 2'd3
  } pstate_t;
endpackage

// File: rtl/spd_req_check.sv
module spd_req_check
  import spd_pkg::*;
(
  input  logic [NREQ-1:0] req,
  input  logic            idle,
  input  logic            dom_on,
  input  logic            sw_off,
  output logic            go,
  output flow_t           go_flow,
  output logic            bad
);
  logic [NREQ-1:0] legal;

  always_comb begin
    legal[FL_DN_HOLD] = idle && dom_on;
    legal[FL_DN_RUN]  = idle && dom_on && sw_off;
    legal[FL_UP_HOLD] = idle && !dom_on;
    legal[FL_UP_RUN]  = idle && !dom_on;
    go      = $onehot(req) && |(req & legal);
    bad     = |req && !go;
    go_flow = FL_DN_HOLD;
    for (int i = 0; i < NREQ; i++)
      if (req[i]) go_flow = flow_t'(2'(i));
  end
endmodule

// File: rtl/spd_count.sv
module spd_count #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/simd_pwr_seq.sv
module simd_pwr_seq
  import spd_pkg::*;
#(
  parameter int HOLD_CYC   = 8,
  parameter int SETTLE_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            sw_off,
  input  logic            pwr_ack,
  output logic            core_rst_n,
  output logic            simd_rst_n,
  output logic            clamp_en,
  output logic            pwr_en,
  output logic [1:0]      status,
  output logic            may_enable,
  output logic            req_err
);
  localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  step_t          step_q;
  flow_t          flow_q, go_flow;
  logic           dom_on_q, go, bad;
  logic [CW-1:0]  cnt;
  pstate_t        ps;

  spd_req_check u_req (
    .req(req), .idle(step_q == ST_IDLE), .dom_on(dom_on_q), .sw_off(sw_off),
    .go(go), .go_flow(go_flow), .bad(bad)
  );

  spd_count #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .clr(!(step_q == ST_HOLD || step_q == ST_SETTLE)),
    .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= ST_HOLD;      // cold power-on runs the held power-down path
      flow_q     <= FL_DN_HOLD;
      core_rst_n <= 1'b0;
      simd_rst_n <= 1'b0;
      clamp_en   <= 1'b0;
      pwr_en     <= 1'b0;
      dom_on_q   <= 1'b0;
      may_enable <= 1'b0;
      req_err    <= 1'b0;
    end else begin
      req_err <= bad;
      unique case (step_q)
        ST_IDLE: if (go) begin
          flow_q <= go_flow;
          unique case (go_flow)
            FL_DN_HOLD: begin
              core_rst_n <= 1'b0; simd_rst_n <= 1'b0; may_enable <= 1'b0;
              step_q <= ST_HOLD;
            end
            FL_DN_RUN: begin
              simd_rst_n <= 1'b0; may_enable <= 1'b0;
              step_q <= ST_HOLD;
            end
            FL_UP_HOLD: begin
              core_rst_n <= 1'b0;
              step_q <= ST_PREP;
            end
            FL_UP_RUN: begin
              pwr_en <= 1'b1;
              step_q <= ST_WAIT_ON;
            end
          endcase
        end
        ST_HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
          clamp_en <= 1'b1;
          step_q   <= ST_CUT;
        end
        ST_CUT: begin
          pwr_en <= 1'b0;
          step_q <= ST_WAIT_OFF;
        end
        ST_WAIT_OFF: if (!pwr_ack) begin
          if (flow_q == FL_DN_HOLD) core_rst_n <= 1'b1;
          dom_on_q <= 1'b0;
          step_q   <= ST_IDLE;
        end
        ST_PREP: begin
          pwr_en <= 1'b1;
          step_q <= ST_WAIT_ON;
        end
        ST_WAIT_ON: if (pwr_ack) begin
          if (flow_q == FL_UP_HOLD) begin
            clamp_en <= 1'b0;
            step_q   <= ST_REL;
          end else begin
            simd_rst_n <= 1'b1;
            step_q     <= ST_SETTLE;
          end
        end
        ST_REL: begin
          core_rst_n <= 1'b1;
          simd_rst_n <= 1'b1;
          dom_on_q   <= 1'b1;
          step_q     <= ST_IDLE;
        end
        ST_SETTLE: if (cnt == CW'(SETTLE_CYC - 1)) begin
          clamp_en   <= 1'b0;
          may_enable <= 1'b1;
          dom_on_q   <= 1'b1;
          step_q     <= ST_IDLE;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (step_q == ST_IDLE)
      ps = dom_on_q ? PS_ON : PS_OFF;
    else if (flow_q == FL_UP_HOLD || flow_q == FL_UP_RUN)
      ps = PS_RISING;
    else
      ps = PS_FALLING;
    status = ps;
  end
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int HOLD_CYC   = 8,
  parameter int SETTLE_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       core_rst_n,
  input logic       simd_rst_n,
  input logic       clamp_en,
  input logic       pwr_en,
  input logic       pwr_ack,
  input logic [1:0] status,
  input logic       may_enable
);
  localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int KW   = $clog2(MAXC + 2);

  logic [KW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (simd_rst_n) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (!simd_rst_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2 R3 R4: reset held long enough before the clamp
  p_hold_before_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> (!simd_rst_n && lo_cnt >= KW'(HOLD_CYC)));

  p_pwr_off_clamped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> (clamp_en && !simd_rst_n));

  p_pwr_on_clamped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (clamp_en && !simd_rst_n));

  p_unclamp_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_en) |-> (pwr_en && pwr_ack));

  p_simd_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(simd_rst_n) |-> pwr_en);

  p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_en) |-> ((!core_rst_n && !simd_rst_n) || hi_cnt >= KW'(SETTLE_CYC)));

  p_flag_with_unclamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(may_enable) |-> $fell(clamp_en));

  p_on_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> (pwr_en && !clamp_en && simd_rst_n && core_rst_n));
endmodule

bind simd_pwr_seq spd_checker #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .simd_rst_n(simd_rst_n),
  .clamp_en(clamp_en), .pwr_en(pwr_en), .pwr_ack(pwr_ack), .status(status),
  .may_enable(may_enable)
);

// File: tb/simd_pwr_seq_bench.sv
module simd_pwr_seq_bench;
  localparam int HOLD = 8;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] req;
  logic       sw_off;
  logic       pwr_ack;
  logic       core_rst_n, simd_rst_n, clamp_en, pwr_en, may_enable, req_err;
  logic [1:0] status;

  simd_pwr_seq u_simd_pwr_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .sw_off(sw_off), .pwr_ack(pwr_ack),
    .core_rst_n(core_rst_n), .simd_rst_n(simd_rst_n), .clamp_en(clamp_en),
    .pwr_en(pwr_en), .status(status), .may_enable(may_enable), .req_err(req_err)
  );

  int lat = 0;
  logic [3:0] sh = '0;
  always @(posedge clk) sh <= {sh[2:0], pwr_en};
  always_comb pwr_ack = (lat == 0) ? pwr_en : sh[lat-1];

  int t = 0, t0 = 0;
  always @(posedge clk) t++;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  bit core_low_seen, pwr_high_seen;
  always @(negedge clk) begin
    if (!core_rst_n) core_low_seen = 1'b1;
    if (pwr_en) pwr_high_seen = 1'b1;
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (lat %0d)", r, act, exp, lat);
    end
  endtask

  function automatic bit sigv(input int s);
    case (s)
      0: return core_rst_n;
      1: return simd_rst_n;
      2: return clamp_en;
      3: return pwr_en;
      default: return may_enable;
    endcase
  endfunction

  task automatic wait_sig(input int s, input bit v, output int at);
    int k = 0;
    while (sigv(s) != v && k < 400) begin
      @(negedge clk);
      k++;
    end
    at = t - t0;
  endtask

  task automatic pulse(input logic [3:0] v);
    req = v;
    @(negedge clk);
    req = '0;
    t0 = t;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int at;
    rst_n = 1'b0; req = '0; sw_off = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {core_rst_n, simd_rst_n, clamp_en, pwr_en}, 0);
    chk("R1 status", status, 3);

    // R2 cold power-on
    pwr_high_seen = 1'b0;
    rst_n = 1'b1;
    t0 = t;
    wait_sig(2, 1'b1, at);
    chk("R2 clamp time", at, HOLD);
    chk("R2 resets low at clamp", {core_rst_n, simd_rst_n}, 0);
    wait_sig(0, 1'b1, at);
    chk("R2 core release time", at, HOLD + 2);
    chk("R2 simd held", simd_rst_n, 0);
    chk("R2 status off", status, 0);
    chk("R2 power stayed off", pwr_high_seen, 0);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      // R6 power-up, core running
      pulse(4'b1000);
      chk("R9 status rising", status, 1);
      chk("R6 power on", pwr_en, 1);
      wait_sig(1, 1'b1, at);
      chk("R6 simd release time", at, 1 + l);
      chk("R10 clamp held at simd release", clamp_en, 1);
      wait_sig(2, 1'b0, at);
      chk("R6 unclamp time", at, 1 + l + SETTLE);
      chk("R6 may_enable with unclamp", may_enable, 1);
      chk("R9 status on", status, 2);

      // R8 invalid requests while ON
      pulse(4'b0100);
      chk("R8 up while on flagged", req_err, 1);
      chk("R8 up while on no change", {core_rst_n, simd_rst_n, clamp_en, pwr_en, status}, 6'b1101_10);
      pulse(4'b0010);
      chk("R8 down-run without sw_off flagged", req_err, 1);
      chk("R8 down-run without sw_off no change", {simd_rst_n, status}, 3'b1_10);
      pulse(4'b0011);
      chk("R8 two bits flagged", req_err, 1);
      chk("R8 two bits no change", {core_rst_n, simd_rst_n, status}, 4'b11_10);
      @(negedge clk);
      chk("R8 error is one cycle", req_err, 0);

      // R4 power-down, core running
      sw_off = 1'b1;
      core_low_seen = 1'b0;
      pulse(4'b0010);
      sw_off = 1'b0;
      chk("R4 simd reset asserted", simd_rst_n, 0);
      chk("R7 may_enable cleared", may_enable, 0);
      chk("R9 status falling", status, 3);
      wait_sig(2, 1'b1, at);
      chk("R4 clamp time", at, HOLD);
      wait_sig(3, 1'b0, at);
      chk("R4 power off time", at, HOLD + 1);
      @(negedge clk);
      while (status != 2'd0 && (t - t0) < 100) @(negedge clk);
      chk("R4 idle time", t - t0, HOLD + 2 + l);
      chk("R4 core untouched", core_low_seen, 0);

      // R5 power-up, core held
      pulse(4'b0100);
      chk("R5 core reset asserted", core_rst_n, 0);
      wait_sig(3, 1'b1, at);
      chk("R5 power on time", at, 1);
      wait_sig(2, 1'b0, at);
      chk("R5 unclamp time", at, 2 + l);
      chk("R5 resets still low at unclamp", {core_rst_n, simd_rst_n}, 0);
      wait_sig(0, 1'b1, at);
      chk("R5 reset release time", at, 3 + l);
      chk("R5 simd released with core", simd_rst_n, 1);
      chk("R9 status on after held up", status, 2);
      chk("R5 may_enable stays low", may_enable, 0);

      // R3 power-down, core held, with a mid-flow request (R8)
      pulse(4'b0001);
      chk("R3 resets asserted", {core_rst_n, simd_rst_n}, 0);
      @(negedge clk);
      pulse(4'b1000);
      chk("R8 busy request flagged", req_err, 1);
      wait_sig(2, 1'b1, at);
      chk("R3 clamp time after busy request", at + 2, HOLD);
      wait_sig(0, 1'b1, at);
      chk("R3 core release time", at + 2, HOLD + 2 + l);
      chk("R3 simd held", simd_rst_n, 0);
      chk("R3 power off", pwr_en, 0);
      chk("R9 status off", status, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule